// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge gives a host a small window of four 32-bit registers through which it reaches a much larger register space on the far side. The host places a target address in the address register and, for a store, a value in the write-data register. It then writes a command word that asks for a read or a write. The bridge runs exactly one transfer on a back-end register port that uses a request/ready handshake. When the transfer ends it sets an acknowledge flag in the command register. For a read, the fetched word is already in the read-data register at that point.

The host finishes every access by writing zero to the command register. This returns the command register to exactly zero and makes the bridge ready for the next command. Accesses to a target address the bridge must not reach end at once with acknowledge and a sticky error flag, and no back-end transfer takes place. An address is refused when it lies above the top of the range or is not word aligned. A command word that asks for both a read and a write is refused the same way. A back-end that never answers is abandoned after a bounded number of cycles, so the host always sees acknowledge well inside its polling budget.

Top module: `ibr_bridge`

## Requirements
- R1: The host port selects registers by byte offset: 0x0 command, 0x4 target address, 0x8 read data, 0xC write data. The address and write-data registers read back what was written. Host writes to offset 0x8 have no effect. An offset whose two low bits are not zero selects nothing: writes to it are dropped and reads return zero.
- R2: After reset every window register reads zero and the back-end request is low.
- R3: A command value whose bit 1 is set and bit 0 clear, written while idle to a valid address, causes exactly one back-end write. That write carries the address and write data latched at the moment of the command. After the handshake the command register reads 0x6 (bit 2 = acknowledge).
- R4: A command value whose bit 0 is set and bit 1 clear, written while idle to a valid address, causes exactly one back-end read. The returned word is loaded into the read-data register on the same clock edge that sets acknowledge. The command register then reads 0x5.
- R5: Writing zero to the command register after acknowledge makes it read exactly zero from the next cycle on.
- R6: While a command is pending or acknowledged, every command-register write is ignored, including zero while pending. Ignored writes launch no back-end transfer and do not change the command register.
- R7: A target address above MAX_ADDR (default 0xFFF) or with its two low bits not zero launches no back-end transfer. The command ends on the next edge with acknowledge and the error flag (bit 3) set, so the command register reads 0xD for a read or 0xE for a write. A refused read sets the read-data register to zero.
- R8: A command value with both bit 0 and bit 1 set is refused like R7 and the command register reads 0xF.
- R9: If the back-end gives no ready within BE_TIMEOUT cycles of request, the request is withdrawn and the command ends with acknowledge and the error flag. For a read, the read-data register becomes zero.
- R10: Once raised, the back-end request and its address, direction and write data hold steady until ready is seen or the timeout ends the transfer.
- R11: A nonzero command value with neither bit 0 nor bit 1 set, written while idle, is ignored and the command register stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_wen | input | 1 | Host write strobe, one cycle per write |
| h_addr | input | 4 | Host byte offset into the window |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for the register at h_addr (combinational) |
| be_req | output | 1 | Back-end transfer request |
| be_we | output | 1 | Back-end direction, 1 = write |
| be_addr | output | 32 | Back-end target address |
| be_wdata | output | 32 | Back-end write data |
| be_ready | input | 1 | Back-end completion, sampled while be_req is high |
| be_rdata | input | 32 | Back-end read data, valid with be_ready |

## Verification
The assertions assume that the back-end raises be_ready only while be_req is high, for one cycle per transfer. They also assume that the host drives h_wen for a single cycle per register write. The bench back-end model answers only a request it sees and drops ready on the following edge. Its latency can be set per test, and it can be told never to answer, which drives the timeout path. All host writes come from a task that pulses the strobe for exactly one cycle.

// File: rtl/ibr_pkg.sv
// Shared constants and types for the indirect register bridge.
// Assumes a 4-register window addressed by word index h_addr[3:2].
package ibr_pkg;

    // Word index of each window register (byte offset >> 2)
    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_RDAT = 2'd2;
    localparam logic [1:0] SEL_WDAT = 2'd3;

    // Bit positions inside the command register
    localparam int CMD_RD_BIT  = 0;
    localparam int CMD_WR_BIT  = 1;
    localparam int CMD_ACK_BIT = 2;
    localparam int CMD_ERR_BIT = 3;

    // Command engine states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } ibr_state_e;

endpackage

// File: rtl/ibr_csr_regs.sv
// Host-side register window: decodes the host port, holds the target
// address and write-data registers and multiplexes host read data.
// Assumes h_wen is a one-cycle strobe; the command and read-data values
// are owned by the command engine and only viewed here.
module ibr_csr_regs
    import ibr_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_wen,
    input  logic [3:0]    h_addr,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic [DW-1:0] cmd_view,
    input  logic [DW-1:0] rdat_view,
    output logic [AW-1:0] tgt_addr,
    output logic [DW-1:0] tgt_wdata,
    output logic          cmd_wr_stb,
    output logic [DW-1:0] cmd_wr_val
);

    logic       aligned;
    logic [1:0] sel;

    assign aligned    = (h_addr[1:0] == 2'b00);
    assign sel        = h_addr[3:2];
    assign cmd_wr_stb = h_wen && aligned && (sel == SEL_CMD);
    assign cmd_wr_val = h_wdata;

    // Store host writes to the target-address and write-data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_addr  <= '0;
            tgt_wdata <= '0;
        end else if (h_wen && aligned) begin
            if (sel == SEL_ADDR) tgt_addr  <= AW'(h_wdata);
            if (sel == SEL_WDAT) tgt_wdata <= h_wdata;
        end
    end

    // Select the register the host is reading
    always_comb begin
        h_rdata = '0;
        if (aligned) begin
            unique case (sel)
                SEL_CMD:  h_rdata = cmd_view;
                SEL_ADDR: h_rdata = DW'(tgt_addr);
                SEL_RDAT: h_rdata = rdat_view;
                SEL_WDAT: h_rdata = tgt_wdata;
                default:  h_rdata = '0;
            endcase
        end
    end

    // R1: a write to the read-data offset never changes the other host registers
    a_r1_rdat_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wen && aligned && sel == SEL_RDAT) |=> ($stable(tgt_addr) && $stable(tgt_wdata)));

endmodule

// File: rtl/ibr_range_chk.sv
// Target-address legality check: the address must not exceed MAX_ADDR
// and must be a multiple of STRIDE (a power of two). Pure combinational.
module ibr_range_chk #(
    parameter int          AW       = 32,
    parameter int unsigned MAX_ADDR = 32'hFFF,
    parameter int unsigned STRIDE   = 4
) (
    input  logic [AW-1:0] addr,
    output logic          addr_ok
);

    localparam int SB = $clog2(STRIDE);

    logic in_range;
    logic aligned;

    assign in_range = (addr <= AW'(MAX_ADDR));

    // Alignment test only exists when the stride is wider than one byte
    generate
        if (SB == 0) begin : g_no_align
            assign aligned = 1'b1;
        end else begin : g_align
            assign aligned = (addr[SB-1:0] == '0);
        end
    endgenerate

    assign addr_ok = in_range && aligned;

endmodule

// File: rtl/ibr_cmd_fsm.sv
// Command engine: accepts read/write commands while idle, refuses illegal
// ones at once, otherwise runs one request/ready transfer on the back-end
// with a cycle-count timeout, then holds acknowledge until a zero write.
// Assumes be_ready is only raised while be_req is high.
module ibr_cmd_fsm
    import ibr_pkg::*;
#(
    parameter int DW         = 32,
    parameter int AW         = 32,
    parameter int BE_TIMEOUT = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr_stb,
    input  logic [DW-1:0] cmd_wr_val,
    input  logic [AW-1:0] tgt_addr,
    input  logic [DW-1:0] tgt_wdata,
    input  logic          addr_ok,
    output logic [DW-1:0] cmd_view,
    output logic [DW-1:0] rdat_view,
    output logic          be_req,
    output logic          be_we,
    output logic [AW-1:0] be_addr,
    output logic [DW-1:0] be_wdata,
    input  logic          be_ready,
    input  logic [DW-1:0] be_rdata
);

    localparam int TW = (BE_TIMEOUT > 1) ? $clog2(BE_TIMEOUT) : 1;
    localparam logic [TW-1:0] TMO_LAST = TW'(BE_TIMEOUT - 1);

    ibr_state_e    state;
    logic          rd_q, wr_q, ack_q, err_q;
    logic [AW-1:0] addr_lat;
    logic [DW-1:0] wdat_lat;
    logic [DW-1:0] rdat_q;
    logic [TW-1:0] tmo_cnt;

    logic want_rd, want_wr, is_clear, start, bad, tmo_hit;

    assign want_rd  = cmd_wr_val[CMD_RD_BIT];
    assign want_wr  = cmd_wr_val[CMD_WR_BIT];
    assign is_clear = (cmd_wr_val == '0);
    assign start    = cmd_wr_stb && (state == ST_IDLE) && (want_rd || want_wr);
    assign bad      = (want_rd && want_wr) || !addr_ok;
    assign tmo_hit  = (tmo_cnt == TMO_LAST);

    // Advance the command engine and latch transfer data, results and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            rd_q     <= 1'b0;
            wr_q     <= 1'b0;
            ack_q    <= 1'b0;
            err_q    <= 1'b0;
            addr_lat <= '0;
            wdat_lat <= '0;
            rdat_q   <= '0;
            tmo_cnt  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        rd_q     <= want_rd;
                        wr_q     <= want_wr;
                        addr_lat <= tgt_addr;
                        wdat_lat <= tgt_wdata;
                        tmo_cnt  <= '0;
                        if (bad) begin
                            ack_q <= 1'b1;
                            err_q <= 1'b1;
                            if (want_rd) rdat_q <= '0;
                            state <= ST_DONE;
                        end else begin
                            state <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (be_ready) begin
                        if (rd_q) rdat_q <= be_rdata;
                        ack_q <= 1'b1;
                        state <= ST_DONE;
                    end else if (tmo_hit) begin
                        if (rd_q) rdat_q <= '0;
                        ack_q <= 1'b1;
                        err_q <= 1'b1;
                        state <= ST_DONE;
                    end else begin
                        tmo_cnt <= tmo_cnt + 1'b1;
                    end
                end
                ST_DONE: begin
                    if (cmd_wr_stb && is_clear) begin
                        rd_q  <= 1'b0;
                        wr_q  <= 1'b0;
                        ack_q <= 1'b0;
                        err_q <= 1'b0;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Present the command register and the back-end request
    always_comb begin
        cmd_view              = '0;
        cmd_view[CMD_RD_BIT]  = rd_q;
        cmd_view[CMD_WR_BIT]  = wr_q;
        cmd_view[CMD_ACK_BIT] = ack_q;
        cmd_view[CMD_ERR_BIT] = err_q;
    end

    assign rdat_view = rdat_q;
    assign be_req    = (state == ST_ISSUE);
    assign be_we     = wr_q;
    assign be_addr   = addr_lat;
    assign be_wdata  = wdat_lat;

    // R5: a zero write after acknowledge leaves the command register at zero
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && cmd_wr_stb && is_clear) |=> (cmd_view == '0));

    // R6: command writes during an acknowledged command change nothing
    a_r6_ignore_acked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && cmd_wr_stb && !is_clear) |=> ($stable(cmd_view) && !be_req));

    // R6: command writes during a pending transfer do not drop the request
    a_r6_ignore_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && !be_ready && !tmo_hit && cmd_wr_stb) |=> be_req);

    // R7 / R8: a refused command acknowledges with error and never requests
    a_r7_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (start && bad) |=> (!be_req && cmd_view[CMD_ACK_BIT] && cmd_view[CMD_ERR_BIT]));

    // R3 / R4: clean acknowledge only follows a completed handshake
    a_r4_ack_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_q) && !err_q) |-> $past(be_req && be_ready));

    // R7: the error flag never stands without acknowledge
    a_r7_err_has_ack: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> ack_q);

    // R9: the wait counter stays inside the timeout window
    a_r9_tmo_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_cnt <= TMO_LAST);

    // R10: request and its payload hold until ready or timeout
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && !be_ready && !tmo_hit) |=>
            (be_req && $stable(be_addr) && $stable(be_we) && $stable(be_wdata)));

endmodule

// File: rtl/ibr_bridge.sv
// Indirect register access bridge top: a four-register host window that
// turns read/write commands into single back-end request/ready transfers.
// Assumes a one-cycle host write strobe and a back-end that answers only
// an asserted request.
module ibr_bridge #(
    parameter int          DW         = 32,
    parameter int          AW         = 32,
    parameter int unsigned MAX_ADDR   = 32'hFFF,
    parameter int unsigned STRIDE     = 4,
    parameter int          BE_TIMEOUT = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_wen,
    input  logic [3:0]    h_addr,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    output logic          be_req,
    output logic          be_we,
    output logic [AW-1:0] be_addr,
    output logic [DW-1:0] be_wdata,
    input  logic          be_ready,
    input  logic [DW-1:0] be_rdata
);

    logic [DW-1:0] cmd_view;
    logic [DW-1:0] rdat_view;
    logic [AW-1:0] tgt_addr;
    logic [DW-1:0] tgt_wdata;
    logic          cmd_wr_stb;
    logic [DW-1:0] cmd_wr_val;
    logic          addr_ok;

    ibr_csr_regs #(.DW(DW), .AW(AW)) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .h_wen      (h_wen),
        .h_addr     (h_addr),
        .h_wdata    (h_wdata),
        .h_rdata    (h_rdata),
        .cmd_view   (cmd_view),
        .rdat_view  (rdat_view),
        .tgt_addr   (tgt_addr),
        .tgt_wdata  (tgt_wdata),
        .cmd_wr_stb (cmd_wr_stb),
        .cmd_wr_val (cmd_wr_val)
    );

    ibr_range_chk #(.AW(AW), .MAX_ADDR(MAX_ADDR), .STRIDE(STRIDE)) u_rng (
        .addr    (tgt_addr),
        .addr_ok (addr_ok)
    );

    ibr_cmd_fsm #(.DW(DW), .AW(AW), .BE_TIMEOUT(BE_TIMEOUT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr_stb (cmd_wr_stb),
        .cmd_wr_val (cmd_wr_val),
        .tgt_addr   (tgt_addr),
        .tgt_wdata  (tgt_wdata),
        .addr_ok    (addr_ok),
        .cmd_view   (cmd_view),
        .rdat_view  (rdat_view),
        .be_req     (be_req),
        .be_we      (be_we),
        .be_addr    (be_addr),
        .be_wdata   (be_wdata),
        .be_ready   (be_ready),
        .be_rdata   (be_rdata)
    );

    // R2: no request may appear while reset is applied
    a_r2_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !be_req);

endmodule

// File: tb/ibr_bridge_bench.sv
// Scoreboard bench: host tasks push each expected back-end transfer into
// a queue; a monitor pops and compares at every request/ready handshake.
module ibr_bridge_bench;

    localparam int TMO = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wen = 1'b0;
    logic [3:0]  h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        be_req, be_we;
    logic [31:0] be_addr, be_wdata;
    logic        be_ready;
    logic [31:0] be_rdata;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ibr_bridge #(.BE_TIMEOUT(TMO)) u_ibr_bridge (
        .clk(clk), .rst_n(rst_n), .h_wen(h_wen), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .be_req(be_req), .be_we(be_we),
        .be_addr(be_addr), .be_wdata(be_wdata), .be_ready(be_ready),
        .be_rdata(be_rdata)
    );

    // Back-end register model with settable latency and a no-answer mode
    logic [31:0] mem [1024];
    logic [31:0] shadow [1024];
    int lat = 0;
    bit hang = 1'b0;
    int cnt = 0;

    function automatic logic [31:0] seed_word(int i);
        return (i * 32'h01010101) ^ 32'hC0DE0000;
    endfunction

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i]    = seed_word(i);
            shadow[i] = seed_word(i);
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            be_ready <= 1'b0;
            be_rdata <= '0;
            cnt      <= 0;
        end else begin
            be_ready <= 1'b0;
            if (!be_req) cnt <= 0;
            else if (!be_ready && !hang) begin
                if (cnt >= lat) begin
                    be_ready <= 1'b1;
                    be_rdata <= mem[be_addr[11:2]];
                    if (be_we) mem[be_addr[11:2]] <= be_wdata;
                    cnt <= 0;
                end else cnt <= cnt + 1;
            end
        end
    end

    // Scoreboard of expected back-end transfers: {we, addr, wdata}
    logic [64:0] expq [$];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare every handshake against the head of the queue
    always @(negedge clk) begin
        if (rst_n && be_req && be_ready) begin
            if (expq.size() == 0) begin
                chk("R6 unexpected back-end transfer", be_addr, 32'hFFFFFFFF);
            end else begin
                logic [64:0] e;
                e = expq.pop_front();
                chk("R3/R4 back-end direction", {31'd0, be_we}, {31'd0, e[64]});
                chk("R3/R4 back-end address", be_addr, e[63:32]);
                if (e[64]) chk("R3 back-end write data", be_wdata, e[31:0]);
            end
        end
    end

    task automatic hwr(logic [3:0] off, logic [31:0] d);
        @(negedge clk);
        h_wen = 1'b1; h_addr = off; h_wdata = d;
        @(negedge clk);
        h_wen = 1'b0;
    endtask

    task automatic hrd(logic [3:0] off, output logic [31:0] d);
        @(negedge clk);
        h_addr = off;
        #1;
        d = h_rdata;
    endtask

    task automatic wait_ack(output logic [31:0] c);
        c = '0;
        for (int i = 0; i < 400; i++) begin
            hrd(4'h0, c);
            if (c[2]) break;
        end
    endtask

    // Full write sequence: data, address, command, acknowledge, clear
    task automatic do_write(logic [31:0] a, logic [31:0] d, logic [31:0] exp_cmd, string tag);
        logic [31:0] c;
        hwr(4'hC, d);
        hwr(4'h4, a);
        if (exp_cmd == 32'h6) begin
            expq.push_back({1'b1, a, d});
            shadow[a[11:2]] = d;
        end
        hwr(4'h0, 32'h2);
        wait_ack(c);
        chk(tag, c, exp_cmd);
        hwr(4'h0, 32'h0);
        hrd(4'h0, c);
        chk("R5 command cleared after write", c, 32'h0);
    endtask

    // Full read sequence: address, command, acknowledge, data, clear
    task automatic do_read(logic [31:0] a, logic [31:0] exp_cmd, logic [31:0] exp_d, string tag);
        logic [31:0] c, d;
        hwr(4'h4, a);
        if (exp_cmd == 32'h5) expq.push_back({1'b0, a, 32'h0});
        hwr(4'h0, 32'h1);
        wait_ack(c);
        chk(tag, c, exp_cmd);
        hrd(4'h8, d);
        chk({tag, " data"}, d, exp_d);
        hwr(4'h0, 32'h0);
        hrd(4'h0, c);
        chk("R5 command cleared after read", c, 32'h0);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R2: reset state
        hrd(4'h0, v); chk("R2 reset command", v, 32'h0);
        hrd(4'h4, v); chk("R2 reset address", v, 32'h0);
        hrd(4'h8, v); chk("R2 reset read data", v, 32'h0);
        hrd(4'hC, v); chk("R2 reset write data", v, 32'h0);
        chk("R2 reset request", {31'd0, be_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: readback, read-only data register, unaligned offsets
        hwr(4'h4, 32'h0000_0ABC); hrd(4'h4, v); chk("R1 address readback", v, 32'h0000_0ABC);
        hwr(4'hC, 32'h1234_5678); hrd(4'hC, v); chk("R1 write-data readback", v, 32'h1234_5678);
        hwr(4'h8, 32'hDEAD_BEEF); hrd(4'h8, v); chk("R1 read data not host-writable", v, 32'h0);
        hwr(4'h5, 32'h0000_0FFF); hrd(4'h4, v); chk("R1 unaligned offset write dropped", v, 32'h0000_0ABC);
        hrd(4'h6, v); chk("R1 unaligned offset reads zero", v, 32'h0);

        // R11: idle command without rd/wr bits
        hwr(4'h0, 32'h4); hrd(4'h0, v); chk("R11 no-op command ignored", v, 32'h0);
        hwr(4'h0, 32'hF0); hrd(4'h0, v); chk("R11 high-bit command ignored", v, 32'h0);

        // R3 / R4: basic transfers, varied latency
        lat = 0;
        do_write(32'h010, 32'hA5A5_5A5A, 32'h6, "R3 write ack");
        do_read (32'h010, 32'h5, 32'hA5A5_5A5A, "R4 read ack");
        lat = 5;
        do_read (32'h100, 32'h5, shadow[32'h100 >> 2], "R4 read seeded word");
        do_write(32'hFFC, 32'h0F0F_00FF, 32'h6, "R3 write top word");
        lat = 2;
        do_read (32'hFFC, 32'h5, 32'h0F0F_00FF, "R4 read top word");
        do_read (32'h000, 32'h5, shadow[0], "R4 read bottom word");

        // R7: out of range and misaligned
        do_write(32'h1000, 32'h1111_1111, 32'hE, "R7 write above range");
        do_read (32'h1000, 32'hD, 32'h0, "R7 read above range");
        do_read (32'h012, 32'hD, 32'h0, "R7 read misaligned");
        do_write(32'h8000_0010, 32'h2222_2222, 32'hE, "R7 write far above range");
        do_read (32'h010, 32'h5, 32'hA5A5_5A5A, "R7 refused write left target intact");

        // R8: both bits set
        hwr(4'h4, 32'h020);
        hwr(4'h0, 32'h3);
        wait_ack(v); chk("R8 both bits refused", v, 32'hF);
        hwr(4'h0, 32'h0); hrd(4'h0, v); chk("R5 clear after invalid", v, 32'h0);

        // R6 / R10: commands during a pending read, and during acknowledge
        lat = 30;
        hwr(4'h4, 32'h020);
        expq.push_back({1'b0, 32'h020, 32'h0});
        hwr(4'h0, 32'h1);
        hwr(4'h4, 32'h040);
        hwr(4'h0, 32'h2);
        hwr(4'h0, 32'h0);
        hrd(4'h0, v); chk("R6 pending command unchanged", v, 32'h1);
        chk("R10 request held", {31'd0, be_req}, 32'h1);
        chk("R10 request address held", be_addr, 32'h020);
        wait_ack(v); chk("R6 original read acknowledged", v, 32'h5);
        hrd(4'h8, v); chk("R6 original read data", v, shadow[32'h020 >> 2]);
        hwr(4'h0, 32'h2);
        hrd(4'h0, v); chk("R6 acked command unchanged", v, 32'h5);
        hwr(4'h0, 32'h0); hrd(4'h0, v); chk("R5 clear after ignored", v, 32'h0);

        // R9: back-end never answers
        lat = 0;
        hang = 1'b1;
        hwr(4'h4, 32'h030);
        hwr(4'h0, 32'h1);
        hrd(4'h0, v); chk("R9 still pending before timeout", v, 32'h1);
        wait_ack(v); chk("R9 timeout acknowledges with error", v, 32'hD);
        hrd(4'h8, v); chk("R9 timeout read data zero", v, 32'h0);
        chk("R9 request withdrawn", {31'd0, be_req}, 32'h0);
        hwr(4'h0, 32'h0);
        hang = 1'b0;
        do_read(32'h030, 32'h5, shadow[32'h030 >> 2], "R9 recovery read");

        chk("R3/R4 all expected transfers seen", expq.size(), 32'h0);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule